// File: doc/BRIEF.md
# Cascadable Wiper Position Counter Bank

This block keeps the wiper setting of four digitally controlled resistor arrays. Each array has one 8-bit register. The low six bits give the tap position. Bit 6 turns the wiper off (isolates it). Bit 7 chains the array to the next one up. For each array the block drives 64 tap-enable lines, of which at most one is high. A disabled wiper drives all of its lines low.

A register can change in four ways:
- the host writes a whole byte to it;
- a stored data-register byte is copied into it, for one array or for all four at once;
- while reset is held, it takes a recall value that stands for the power-up copy of stored slot zero;
- in stepping mode, each rising clock edge on the serial bus moves the selected wiper one position. The level of the data line decides the direction.

When chaining is on, a step past the end of one array hands the active wiper to the neighbouring array. The two arrays then form one long resistor. Stepping mode stops at the next START or STOP seen on the bus.

The serial bus lines come into the block already synchronised to `clk`. The block finds bus edges by comparing each line with its value one cycle earlier. Register changes appear one `clk` cycle after the edge that caused them.

Top module: `wiper_bank`

## Requirements
- R1: While `rst_n` is low, each register loads its byte from `recall_val` (array n in bits 8n+7..8n). The value shows on `wcr_q` and on the tap lines after the next clock edge.
- R2: If bit 6 of array n is 0 and its position is k (00h to 3Fh), then exactly one line of `tap_sel` is high in that array's group: line 64n+k. Line 64n+0 is the low terminal and line 64n+63 is the high terminal.
- R3: If bit 6 of array n is 1, all 64 tap lines of array n are low. The position and bit 7 can still be read on `wcr_q`.
- R4: A cycle with `wr_en` high writes `wr_data` into array `wr_sel` at the next edge. The other arrays keep their values.
- R5: A cycle with `xfer_en` high copies byte n of `xfer_data` into array `xfer_sel`. If `xfer_all` is also high, every array n takes byte n of `xfer_data` in that one cycle.
- R6: A one-cycle `step_arm` pulse starts stepping mode on array `step_sel` and raises `step_active`. In this mode, each rising edge of `scl` moves the position of the target array one step: up if `sda` is 1, down if `sda` is 0. Bits 7 and 6 of that array do not change.
- R7: If bit 7 of the target array is 0, an up step at 3Fh leaves it at 3Fh. A down step at 00h leaves it at 00h.
- R8: If the target array n has bit 7 set and sits at 3Fh, an up step does three things. Array (n+1) mod 4 gets position 00h and bit 6 cleared. Array n gets bit 6 set. Array (n+1) mod 4 becomes the target.
- R9: If the target array n sits at 00h and array (n-1) mod 4 has bit 7 set, a down step does three things. Array (n-1) mod 4 gets position 3Fh and bit 6 cleared. Array n gets bit 6 set. Array (n-1) mod 4 becomes the target.
- R10: A START (`sda` falls while `scl` stays high) or a STOP (`sda` rises while `scl` stays high) ends stepping mode. After that, `step_active` is low and later `scl` edges change nothing.
- R11: Sources are served in a fixed order: `wr_en` first, then `xfer_en`, then a step. A step that meets a write or copy in the same cycle is lost. `scl` edges outside stepping mode have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; loads recall values |
| recall_val | input | 32 | Power-up values, byte n for array n |
| wr_en | input | 1 | Direct write strobe |
| wr_sel | input | 2 | Array chosen for direct write |
| wr_data | input | 8 | Byte for direct write |
| xfer_en | input | 1 | Copy-from-data-register strobe |
| xfer_all | input | 1 | Copy into all four arrays at once |
| xfer_sel | input | 2 | Array chosen for a single copy |
| xfer_data | input | 32 | Data-register bytes, byte n for array n |
| step_arm | input | 1 | Starts stepping mode |
| step_sel | input | 2 | Array that stepping starts on |
| scl | input | 1 | Synchronised bus clock |
| sda | input | 1 | Synchronised bus data |
| step_active | output | 1 | Stepping mode is on |
| wcr_q | output | 32 | Register contents, byte n for array n |
| tap_sel | output | 256 | Tap enables, 64 per array |

## Verification
The bench drives each array to both end positions and then steps past them. A design that wrapped there would show position 00h after 3Fh instead of holding at 3Fh. The bench also hands the wiper from one array to the next in both directions, including the wrap-around between arrays 3 and 0. A design that got this wrong would leave both wipers enabled, or would keep stepping the old array. The bench ends stepping mode once with a STOP and once with a START, and then checks that later clock pulses leave the position alone. Finally, it lands a write on the same cycle as a step. A design with the order reversed would show the stepped value, not the written byte.

// File: rtl/wiper_bank.sv
module wiper_bank #(
  parameter int NPOT = 4,
  parameter int PW   = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPOT*(PW+2)-1:0]  recall_val,
  input  logic                    wr_en,
  input  logic [$clog2(NPOT)-1:0] wr_sel,
  input  logic [PW+1:0]           wr_data,
  input  logic                    xfer_en,
  input  logic                    xfer_all,
  input  logic [$clog2(NPOT)-1:0] xfer_sel,
  input  logic [NPOT*(PW+2)-1:0]  xfer_data,
  input  logic                    step_arm,
  input  logic [$clog2(NPOT)-1:0] step_sel,
  input  logic                    scl,
  input  logic                    sda,
  output logic                    step_active,
  output logic [NPOT*(PW+2)-1:0]  wcr_q,
  output logic [NPOT*(1<<PW)-1:0] tap_sel
);
  localparam int RW   = PW + 2;
  localparam int TAPS = 1 << PW;
  localparam int SW   = $clog2(NPOT);
  localparam int CMB  = RW - 1;
  localparam int DWB  = RW - 2;
  localparam logic [PW-1:0] TOP = '1;

  logic [RW-1:0] wcr [NPOT];
  logic [SW-1:0] ptr;
  logic          scl_q, sda_q;

  wire scl_rise = scl && !scl_q;
  wire bus_cond = scl && scl_q && (sda != sda_q);
  wire do_step  = step_active && scl_rise && !step_arm && !wr_en && !xfer_en;

  wire [SW-1:0] nxt = ptr + 1'b1;
  wire [SW-1:0] prv = ptr - 1'b1;
  wire [RW-1:0] cur = wcr[ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPOT; i++) wcr[i] <= recall_val[i*RW +: RW];
      step_active <= 1'b0;
      ptr         <= '0;
      scl_q       <= 1'b0;
      sda_q       <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
      if (step_arm) begin
        step_active <= 1'b1;
        ptr         <= step_sel;
      end else if (bus_cond) begin
        step_active <= 1'b0;
      end
      if (wr_en) begin
        wcr[wr_sel] <= wr_data;
      end else if (xfer_en) begin
        for (int i = 0; i < NPOT; i++)
          if (xfer_all || xfer_sel == SW'(i)) wcr[i] <= xfer_data[i*RW +: RW];
      end else if (do_step) begin
        if (sda) begin
          if (cur[PW-1:0] != TOP) begin
            wcr[ptr][PW-1:0] <= cur[PW-1:0] + 1'b1;
          end else if (cur[CMB]) begin
            wcr[ptr][DWB]    <= 1'b1;
            wcr[nxt][PW-1:0] <= '0;
            wcr[nxt][DWB]    <= 1'b0;
            ptr              <= nxt;
          end
        end else begin
          if (cur[PW-1:0] != '0) begin
            wcr[ptr][PW-1:0] <= cur[PW-1:0] - 1'b1;
          end else if (wcr[prv][CMB]) begin
            wcr[ptr][DWB]    <= 1'b1;
            wcr[prv][PW-1:0] <= TOP;
            wcr[prv][DWB]    <= 1'b0;
            ptr              <= prv;
          end
        end
      end
    end
  end

  assert_mode_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cond && !step_arm |=> !step_active);

  for (genvar p = 0; p < NPOT; p++) begin : g_pot
    localparam int NX = (p + 1) % NPOT;
    wire [TAPS-1:0] taps = tap_sel[p*TAPS +: TAPS];

    assign wcr_q[p*RW +: RW]     = wcr[p];
    assign tap_sel[p*TAPS +: TAPS] = wcr[p][DWB] ? '0 : (TAPS'(1) << wcr[p][PW-1:0]);

    assert_tap_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(taps));

    assert_dark_wiper_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wcr_q[p*RW + DWB] |-> taps == '0);

    assert_write_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_sel == SW'(p) |=> wcr_q[p*RW +: RW] == $past(wr_data));

    assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      do_step && ptr == SW'(p) && sda && wcr[p][PW-1:0] == TOP && !wcr[p][CMB]
      |=> wcr[p][PW-1:0] == TOP);

    assert_carry_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
      do_step && ptr == SW'(p) && sda && wcr[p][PW-1:0] == TOP && wcr[p][CMB]
      |=> wcr[p][DWB] && !wcr[NX][DWB] && wcr[NX][PW-1:0] == '0);
  end
endmodule

// File: tb/wiper_bank_tb.sv
module wiper_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] recall_val = {8'h80, 8'h50, 8'h3F, 8'h05};
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic        xfer_en = 1'b0, xfer_all = 1'b0;
  logic [1:0]  xfer_sel = '0;
  logic [31:0] xfer_data = '0;
  logic        step_arm = 1'b0;
  logic [1:0]  step_sel = '0;
  logic        scl = 1'b0, sda = 1'b1;
  logic        step_active;
  logic [31:0] wcr_q;
  logic [255:0] tap_sel;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wiper_bank u_dut (
    .clk(clk), .rst_n(rst_n), .recall_val(recall_val),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .xfer_en(xfer_en), .xfer_all(xfer_all), .xfer_sel(xfer_sel), .xfer_data(xfer_data),
    .step_arm(step_arm), .step_sel(step_sel), .scl(scl), .sda(sda),
    .step_active(step_active), .wcr_q(wcr_q), .tap_sel(tap_sel)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_pot(string tag, int p, logic [7:0] e);
    chk(tag, 64'(wcr_q[p*8 +: 8]), 64'(e));
    chk(tag, tap_sel[p*64 +: 64], e[6] ? 64'd0 : (64'd1 << e[5:0]));
  endtask

  task automatic wr(int p, logic [7:0] d);
    wr_en = 1'b1; wr_sel = 2'(p); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic arm(int p);
    step_arm = 1'b1; step_sel = 2'(p);
    @(negedge clk);
    step_arm = 1'b0;
  endtask

  task automatic pulse(logic dir);
    sda = dir;
    @(negedge clk);
    scl = 1'b1;
    @(negedge clk);
    scl = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk_pot("R1 R2 pot0", 0, 8'h05);
    chk_pot("R1 R2 pot1 high end", 1, 8'h3F);
    chk_pot("R1 R3 pot2 dark", 2, 8'h50);
    chk_pot("R1 R2 pot3 low end", 3, 8'h80);
    chk("R1 idle", 64'(step_active), 64'd0);
  endtask

  task automatic t_write;
    wr(2, 8'h21);
    chk_pot("R4 pot2", 2, 8'h21);
    chk_pot("R4 pot0 kept", 0, 8'h05);
    wr(1, 8'h6A);
    chk_pot("R3 disabled write", 1, 8'h6A);
    chk_pot("R4 pot2 kept", 2, 8'h21);
  endtask

  task automatic t_xfer;
    xfer_data = {8'h13, 8'h24, 8'h35, 8'h86};
    xfer_en = 1'b1; xfer_sel = 2'd0;
    @(negedge clk);
    xfer_en = 1'b0;
    chk_pot("R5 single", 0, 8'h86);
    chk_pot("R5 single others", 1, 8'h6A);
    xfer_data = {8'h01, 8'h02, 8'h03, 8'h04};
    xfer_en = 1'b1; xfer_all = 1'b1; xfer_sel = 2'd1;
    @(negedge clk);
    xfer_en = 1'b0; xfer_all = 1'b0;
    for (int p = 0; p < 4; p++) chk_pot("R5 global", p, 8'(p + 4 - 2*p));
  endtask

  task automatic t_step;
    wr(0, 8'h3D);
    arm(0);
    chk("R6 armed", 64'(step_active), 64'd1);
    pulse(1'b1); chk_pot("R6 up", 0, 8'h3E);
    pulse(1'b1); chk_pot("R6 up to top", 0, 8'h3F);
    pulse(1'b1); chk_pot("R7 top saturate", 0, 8'h3F);
    wr(0, 8'h01);
    pulse(1'b0); chk_pot("R6 down", 0, 8'h00);
    pulse(1'b0); chk_pot("R7 bottom saturate", 0, 8'h00);
    wr(0, 8'h45);
    pulse(1'b1); chk_pot("R6 flags kept", 0, 8'h46);
  endtask

  task automatic t_cascade;
    wr(0, 8'hBF); wr(1, 8'h4A);
    arm(0);
    pulse(1'b1);
    chk_pot("R8 lower off", 0, 8'hFF);
    chk_pot("R8 upper on", 1, 8'h00);
    pulse(1'b1); chk_pot("R8 target moved", 1, 8'h01);
    pulse(1'b0); chk_pot("R9 step down", 1, 8'h00);
    pulse(1'b0);
    chk_pot("R9 back to lower", 0, 8'hBF);
    chk_pot("R9 upper off", 1, 8'h40);
    wr(3, 8'hBF); wr(0, 8'h40);
    arm(3);
    pulse(1'b1);
    chk_pot("R8 wrap 3 to 0", 0, 8'h00);
    chk_pot("R8 wrap pot3 off", 3, 8'hFF);
    pulse(1'b0);
    chk_pot("R9 wrap 0 to 3", 3, 8'hBF);
    chk_pot("R9 wrap pot0 off", 0, 8'h40);
  endtask

  task automatic t_end;
    wr(2, 8'h10);
    arm(2);
    sda = 1'b0;
    @(negedge clk); scl = 1'b1;
    @(negedge clk); sda = 1'b1;
    @(negedge clk); scl = 1'b0;
    @(negedge clk);
    chk_pot("R10 rise before stop steps", 2, 8'h0F);
    chk("R10 stop ends", 64'(step_active), 64'd0);
    pulse(1'b1); chk_pot("R10 after stop", 2, 8'h0F);
    arm(2);
    @(negedge clk); scl = 1'b1;
    @(negedge clk); sda = 1'b0;
    @(negedge clk); scl = 1'b0;
    @(negedge clk);
    chk_pot("R10 rise before start steps", 2, 8'h10);
    chk("R10 start ends", 64'(step_active), 64'd0);
    pulse(1'b0); chk_pot("R10 after start", 2, 8'h10);
  endtask

  task automatic t_priority;
    pulse(1'b1); chk_pot("R11 idle scl", 2, 8'h10);
    arm(2);
    sda = 1'b1;
    @(negedge clk);
    scl = 1'b1; wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h07;
    @(negedge clk);
    scl = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    chk_pot("R11 write wins", 2, 8'h07);
    pulse(1'b1); chk_pot("R11 mode kept", 2, 8'h08);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_write;
    t_xfer;
    t_step;
    t_cascade;
    t_end;
    t_priority;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule